// File: doc/BRIEF.md
# Sectioned Adaptive FIR Echo Filter

This block estimates and removes line echo for a pair of voice channels at the 8 kHz sample rate. It holds two equal sections of adaptive coefficients, `SECT_TAPS` taps each (512 by default, so 64 ms per section). A mode input decides how the sections are used. They can act as two independent cancellers, one per channel. They can be chained into one canceller of twice the length for channel A. Or they can serve the two directions of one channel: section 1 cleans the send path and section 0 cleans the return path. All samples are 16-bit signed linear PCM.

Each `sample_valid` strobe starts one pass. A single multiply-accumulate unit walks every tap once to form the echo estimate and the reference energy. The estimate is subtracted from the desired sample. If adaptation is enabled, the coefficients are then corrected with a normalized LMS step. The normalizing division is done bit-serially, and a second walk over the taps applies the correction. A one-cycle `done` pulse marks the end of the pass, and the outputs stay valid until the next pass. Companding, serial framing and non-linear processing sit outside this block.

Top module: `echo_fir_pair`

## Requirements
- R1: Synchronous active-high reset clears every coefficient and every stored reference sample, drives `out_a`, `out_b` and `done` low, and so the first sample after reset leaves each desired sample unchanged at the output.
- R2: For each canceller, the estimate is the sum over its taps of coefficient (signed Q15) times stored reference, arithmetically shifted right by 15 and saturated to 16 bits. The output is the desired sample minus that estimate, saturated to 16 bits. Outputs change only when a pass completes.
- R3: `mode` 0 (and the unused code 3) pairs the sections with the channels. Section 0 uses `ref_a` and `snd_a` and produces `out_a`. Section 1 uses `ref_b` and `snd_b` and produces `out_b`. Neither channel affects the other.
- R4: `mode` 1 chains the sections into one canceller of 2*SECT_TAPS taps on `ref_a` and `snd_a`, producing `out_a`. The oldest reference leaving section 0 enters section 1. `out_b` copies `snd_b` unmodified.
- R5: `mode` 2 serves the two directions of one channel. Section 1 uses `ref_a` as reference and `snd_a` as desired, producing `out_a`. Section 0 uses `snd_a` as reference and `ref_a` as desired, producing `out_b`. `ref_b` and `snd_b` are ignored.
- R6: With adaptation on, each canceller computes g = sign(e) * floor(|e| * 2^30 / (E + DELTA)), where e is its output and E is the sum of its squared stored references. Each of its taps then becomes sat16(c + ((g * x) >>> (15 + mu_shift))), where x is that tap's reference.
- R7: With `adapt_en` low at the strobe, coefficients are left untouched, while filtering and output subtraction continue with the held coefficients.
- R8: `mu_shift` (0 to 15) divides the adaptation step by 2^mu_shift, and is sampled with the strobe.
- R9: Each accepted strobe produces exactly one `done` pulse, one cycle wide. A strobe that arrives while a pass is in progress is ignored.
- R10: Estimates, outputs and updated coefficients saturate at +32767 and -32768 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Section assignment: 0 pair, 1 chained, 2 direction split, 3 as 0 |
| sample_valid | input | 1 | Starts a pass on the current inputs |
| adapt_en | input | 1 | Enables the coefficient update for this pass |
| mu_shift | input | 4 | Step-size divider exponent |
| ref_a | input | 16 | Channel A reference sample |
| snd_a | input | 16 | Channel A desired (send) sample |
| ref_b | input | 16 | Channel B reference sample |
| snd_b | input | 16 | Channel B desired (send) sample |
| out_a | output | 16 | Channel A result |
| out_b | output | 16 | Channel B result, or the return-path result in mode 2 |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The bench targets the places where the section wiring differs between modes. In chained mode, an echo placed beyond the first section's span is only cancelled if the oldest sample really crosses into section 1; a design that fed section 1 from `ref_b` there would never remove it. A design that swapped sources in direction-split mode would let `ref_b` and `snd_b` leak into the results, and one that misrouted the update target would adapt against the wrong energy. Further runs freeze adaptation mid-stream, so a design that kept updating would drift from the expected outputs. Other runs push outputs and estimates past full scale, where a wrapping design would flip sign. Still others send a second strobe into a busy pass, where a design that restarted would produce extra `done` pulses and shifted references.

// File: rtl/echo_pkg.sv
package echo_pkg;

    typedef logic signed [15:0] pcm_t;

    localparam int ACC_W = 48;

    typedef enum logic [1:0] {
        M_PAIR    = 2'd0,
        M_CHAIN   = 2'd1,
        M_SPLIT   = 2'd2,
        M_PAIR_B  = 2'd3
    } canc_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MAC,
        S_ERR,
        S_DIV,
        S_UPD,
        S_DONE
    } phase_e;

    function automatic pcm_t sat16(input logic signed [63:0] v);
        if (v > 64'sd32767)
            return 16'sh7fff;
        else if (v < -64'sd32768)
            return 16'sh8000;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/echo_tap_store.sv
module echo_tap_store
    import echo_pkg::*;
#(
    parameter int SECT_TAPS = 512,
    localparam int KW = (SECT_TAPS > 1) ? $clog2(SECT_TAPS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  logic          chain,
    input  pcm_t          in0,
    input  pcm_t          in1,
    input  logic          rd_sec,
    input  logic [KW-1:0] rd_k,
    output pcm_t          rd_x,
    output pcm_t          rd_c,
    input  logic          we,
    input  pcm_t          wr_c
);

    pcm_t hist [2][SECT_TAPS];
    pcm_t coef [2][SECT_TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < SECT_TAPS; k++) begin
                    hist[s][k] <= '0;
                    coef[s][k] <= '0;
                end
            end
        end else begin
            if (shift) begin
                for (int k = SECT_TAPS - 1; k > 0; k--) begin
                    hist[0][k] <= hist[0][k-1];
                    hist[1][k] <= hist[1][k-1];
                end
                hist[0][0] <= in0;
                hist[1][0] <= chain ? hist[0][SECT_TAPS-1] : in1;
            end
            if (we)
                coef[rd_sec][rd_k] <= wr_c;
        end
    end

    assign rd_x = hist[rd_sec][rd_k];
    assign rd_c = coef[rd_sec][rd_k];

    // R7: without a write strobe the addressed coefficient keeps its value
    p_coef_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !we |=> (coef[$past(rd_sec)][$past(rd_k)] == $past(rd_c)));

endmodule

// File: rtl/echo_div.sv
module echo_div #(
    parameter int W = 48,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot
);

    logic [W-1:0]  quo, dvs, dvd;
    logic [W:0]    rem, trial;
    logic [CW-1:0] cnt;
    logic          run;

    assign trial = {rem[W-1:0], quo[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            quo  <= '0;
            dvs  <= '0;
            dvd  <= '0;
            rem  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem <= '0;
                quo <= dividend;
                dvd <= dividend;
                dvs <= divisor;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dvs}) begin
                    rem <= trial - {1'b0, dvs};
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = quo;

    // R6: the quotient is the exact floor of the latched division
    p_div_exact_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (({{W{1'b0}}, quot} * {{W{1'b0}}, dvs} <= {{W{1'b0}}, dvd}) &&
                  ({{W{1'b0}}, quot + 1'b1} * {{W{1'b0}}, dvs} > {{W{1'b0}}, dvd})));

endmodule

// File: rtl/echo_fir_pair.sv
module echo_fir_pair
    import echo_pkg::*;
#(
    parameter int SECT_TAPS = 512,
    parameter int DELTA     = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              sample_valid,
    input  logic              adapt_en,
    input  logic [3:0]        mu_shift,
    input  logic signed [15:0] ref_a,
    input  logic signed [15:0] snd_a,
    input  logic signed [15:0] ref_b,
    input  logic signed [15:0] snd_b,
    output logic signed [15:0] out_a,
    output logic signed [15:0] out_b,
    output logic              done
);

    localparam int KW    = (SECT_TAPS > 1) ? $clog2(SECT_TAPS) : 1;
    localparam int IW    = KW + 1;
    localparam int TOTAL = 2 * SECT_TAPS;

    phase_e                  state;
    logic [IW-1:0]           idx;
    logic                    chain_q, split_q, adapt_q, unit, div_go, div_done;
    logic [3:0]              mu_q;
    pcm_t                    des_q [2];
    pcm_t                    err_q [2];
    pcm_t                    err_c [2];
    logic signed [ACC_W-1:0] acc   [2];
    logic signed [ACC_W-1:0] nrg   [2];
    logic signed [ACC_W-1:0] gain  [2];
    logic [ACC_W-1:0]        div_num, div_den, div_q;

    // ---------------- input routing per mode ----------------
    logic chain_in, split_in;
    pcm_t r0, d0, r1, d1;
    always_comb begin
        chain_in = (canc_mode_e'(mode) == M_CHAIN);
        split_in = (canc_mode_e'(mode) == M_SPLIT);
        r0 = split_in ? snd_a : ref_a;
        d0 = split_in ? ref_a : snd_a;
        r1 = split_in ? ref_a : ref_b;
        d1 = split_in ? snd_a : snd_b;
    end

    // ---------------- tap storage ----------------
    logic          rd_sec, tgt, start_pass;
    logic [KW-1:0] rd_k;
    pcm_t          rd_x, rd_c, new_c;

    assign start_pass = (state == S_IDLE) && sample_valid;
    assign rd_sec     = idx[KW];
    assign rd_k       = idx[KW-1:0];
    assign tgt        = chain_q ? 1'b0 : rd_sec;

    echo_tap_store #(.SECT_TAPS(SECT_TAPS)) i_store (
        .clk    (clk),
        .rst    (rst),
        .shift  (start_pass),
        .chain  (chain_in),
        .in0    (r0),
        .in1    (r1),
        .rd_sec (rd_sec),
        .rd_k   (rd_k),
        .rd_x   (rd_x),
        .rd_c   (rd_c),
        .we     (state == S_UPD),
        .wr_c   (new_c)
    );

    // ---------------- shared arithmetic ----------------
    logic signed [31:0] prod, sq;
    logic signed [63:0] gx, csum;
    logic [4:0]         dsh;
    always_comb begin
        prod  = rd_c * rd_x;
        sq    = rd_x * rd_x;
        dsh   = 5'd15 + {1'b0, mu_q};
        gx    = gain[tgt] * rd_x;
        csum  = (gx >>> dsh) + rd_c;
        new_c = sat16(csum);
    end

    // per-canceller estimate and error
    for (genvar u = 0; u < 2; u++) begin : g_unit
        pcm_t               est;
        logic signed [16:0] diff;
        always_comb begin
            est      = sat16(acc[u] >>> 15);
            diff     = {des_q[u][15], des_q[u]} - {est[15], est};
            err_c[u] = sat16(diff);
        end
    end

    // ---------------- normalization divider ----------------
    logic [16:0] abs_e;
    always_comb begin
        abs_e   = err_q[unit][15] ? 17'(-{err_q[unit][15], err_q[unit]})
                                  : {1'b0, err_q[unit]};
        div_num = ACC_W'(abs_e) << 30;
        div_den = $unsigned(nrg[unit]) + ACC_W'(DELTA);
    end

    echo_div #(.W(ACC_W)) i_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend (div_num),
        .divisor  (div_den),
        .done     (div_done),
        .quot     (div_q)
    );

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            idx     <= '0;
            chain_q <= 1'b0;
            split_q <= 1'b0;
            adapt_q <= 1'b0;
            mu_q    <= '0;
            unit    <= 1'b0;
            div_go  <= 1'b0;
            done    <= 1'b0;
            out_a   <= '0;
            out_b   <= '0;
            for (int u = 0; u < 2; u++) begin
                des_q[u] <= '0;
                err_q[u] <= '0;
                acc[u]   <= '0;
                nrg[u]   <= '0;
                gain[u]  <= '0;
            end
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            case (state)
                S_IDLE: if (sample_valid) begin
                    chain_q  <= chain_in;
                    split_q  <= split_in;
                    adapt_q  <= adapt_en;
                    mu_q     <= mu_shift;
                    des_q[0] <= d0;
                    des_q[1] <= d1;
                    for (int u = 0; u < 2; u++) begin
                        acc[u] <= '0;
                        nrg[u] <= '0;
                    end
                    idx   <= '0;
                    state <= S_MAC;
                end
                S_MAC: begin
                    acc[tgt] <= acc[tgt] + prod;
                    nrg[tgt] <= nrg[tgt] + sq;
                    idx      <= idx + 1'b1;
                    if (idx == IW'(TOTAL - 1))
                        state <= S_ERR;
                end
                S_ERR: begin
                    err_q[0] <= err_c[0];
                    err_q[1] <= err_c[1];
                    out_a    <= split_q ? err_c[1] : err_c[0];
                    out_b    <= chain_q ? des_q[1] : (split_q ? err_c[0] : err_c[1]);
                    unit     <= 1'b0;
                    if (adapt_q) begin
                        div_go <= 1'b1;
                        state  <= S_DIV;
                    end else begin
                        state  <= S_DONE;
                    end
                end
                S_DIV: if (div_done) begin
                    gain[unit] <= err_q[unit][15] ? $signed(-div_q) : $signed(div_q);
                    if (!unit && !chain_q) begin
                        unit   <= 1'b1;
                        div_go <= 1'b1;
                    end else begin
                        idx   <= '0;
                        state <= S_UPD;
                    end
                end
                S_UPD: begin
                    idx <= idx + 1'b1;
                    if (idx == IW'(TOTAL - 1))
                        state <= S_DONE;
                end
                default: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // R9: completion is signalled by a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: results move only when a pass resolves its error
    p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state != S_ERR) |=> ($stable(out_a) && $stable(out_b)));

    // R4: in chained mode channel B passes straight through
    p_chain_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_ERR && chain_q) |=> (out_b == $past(des_q[1])));

endmodule

// File: tb/test_echo_fir_pair.sv
module test_echo_fir_pair;

    localparam int N     = 8;
    localparam int DELTA = 65536;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode = 2'd0;
    logic              sample_valid = 1'b0;
    logic              adapt_en = 1'b0;
    logic [3:0]        mu_shift = 4'd0;
    logic signed [15:0] ref_a = '0, snd_a = '0, ref_b = '0, snd_b = '0;
    logic signed [15:0] out_a, out_b;
    logic              done;

    always #10 clk = ~clk;

    echo_fir_pair #(.SECT_TAPS(N), .DELTA(DELTA)) i_echo_fir_pair (
        .clk(clk), .rst(rst), .mode(mode), .sample_valid(sample_valid),
        .adapt_en(adapt_en), .mu_shift(mu_shift),
        .ref_a(ref_a), .snd_a(snd_a), .ref_b(ref_b), .snd_b(snd_b),
        .out_a(out_a), .out_b(out_b), .done(done)
    );

    int errors = 0;
    int checks = 0;
    int sent   = 0;
    int seen   = 0;

    longint exp_a[$];
    longint exp_b[$];
    string  exp_tag[$];

    longint mc [2*N];
    longint mh [2*N];

    task automatic chk(string tag, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic longint msat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int rnd(int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2*N; k++) begin
            mc[k] = 0;
            mh[k] = 0;
        end
    endtask

    // reference model built from the requirements
    task automatic model_step(int md, longint ra, longint sa, longint rb, longint sb,
                              bit ad, int mu, output longint oa, output longint ob);
        bit chain, split;
        longint r0, d0, r1, d1;
        longint e [2];
        longint en [2];
        longint d [2];
        int nu;
        chain = (md == 1);
        split = (md == 2);
        r0 = split ? sa : ra;
        d0 = split ? ra : sa;
        r1 = split ? ra : rb;
        d1 = split ? sa : sb;
        d[0] = d0;
        d[1] = d1;
        if (chain) begin
            for (int k = 2*N-1; k > 0; k--) mh[k] = mh[k-1];
            mh[0] = r0;
        end else begin
            for (int k = N-1; k > 0; k--) mh[k] = mh[k-1];
            mh[0] = r0;
            for (int k = 2*N-1; k > N; k--) mh[k] = mh[k-1];
            mh[N] = r1;
        end
        nu = chain ? 1 : 2;
        e[1] = 0;
        en[1] = 0;
        for (int u = 0; u < nu; u++) begin
            longint acc, lo, hi, est;
            lo = u * N;
            hi = chain ? 2*N : lo + N;
            acc = 0;
            en[u] = 0;
            for (longint k = lo; k < hi; k++) begin
                acc += mc[k] * mh[k];
                en[u] += mh[k] * mh[k];
            end
            est = msat(acc >>> 15);
            e[u] = msat(d[u] - est);
        end
        if (ad) begin
            for (int u = 0; u < nu; u++) begin
                longint q, g, lo, hi;
                lo = u * N;
                hi = chain ? 2*N : lo + N;
                q = ((e[u] < 0 ? -e[u] : e[u]) <<< 30) / (en[u] + DELTA);
                g = (e[u] < 0) ? -q : q;
                for (longint k = lo; k < hi; k++)
                    mc[k] = msat(mc[k] + ((g * mh[k]) >>> (15 + mu)));
            end
        end
        oa = split ? e[1] : e[0];
        ob = chain ? sb : (split ? e[0] : e[1]);
    endtask

    // driver: computes expectation, queues it, then applies the strobe
    task automatic send(int md, int ra, int sa, int rb, int sb, bit ad, int mu,
                        string tag, bit extra);
        longint oa, ob;
        model_step(md, ra, sa, rb, sb, ad, mu, oa, ob);
        wait (exp_a.size() == 0);
        @(negedge clk);
        exp_a.push_back(oa);
        exp_b.push_back(ob);
        exp_tag.push_back(tag);
        mode = 2'(md);
        ref_a = 16'(ra); snd_a = 16'(sa); ref_b = 16'(rb); snd_b = 16'(sb);
        adapt_en = ad;
        mu_shift = 4'(mu);
        sample_valid = 1'b1;
        sent++;
        @(negedge clk);
        sample_valid = 1'b0;
        if (extra) begin
            repeat (4) @(negedge clk);
            ref_a = 16'sd12345; snd_a = -16'sd9999;
            ref_b = -16'sd7777; snd_b = 16'sd4321;
            sample_valid = 1'b1;
            @(negedge clk);
            sample_valid = 1'b0;
        end
        wait (exp_a.size() == 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // monitor: pops expectations as passes complete
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) chk("R9", "done width", longint'(done), 0);
            prev_done = done;
            if (done) begin
                seen++;
                if (exp_a.size() == 0) begin
                    chk("R9", "unexpected done", 1, 0);
                end else begin
                    string t;
                    t = exp_tag.pop_front();
                    chk(t, "out_a", longint'(out_a), exp_a.pop_front());
                    chk(t, "out_b", longint'(out_b), exp_b.pop_front());
                end
            end
        end else begin
            prev_done = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    int pa [64];
    int pb [64];

    initial begin
        // R1: reset state, then an untrained pass returns the desired sample
        repeat (3) @(negedge clk);
        chk("R1", "done", longint'(done), 0);
        chk("R1", "out_a", longint'(out_a), 0);
        chk("R1", "out_b", longint'(out_b), 0);
        do_reset();
        send(0, 1000, 2500, -3000, -700, 1'b1, 1, "R1", 1'b0);

        // R3/R6: independent channels with distinct echo paths
        do_reset();
        for (int n = 0; n < 40; n++) begin
            pa[n] = rnd(8000);
            pb[n] = rnd(8000);
            send(0, pa[n], (n >= 3 ? pa[n-3] / 2 : 0) + rnd(40),
                 pb[n], (n >= 5 ? -pb[n-5] / 4 : 0) + rnd(40), 1'b1, 1, "R3", 1'b0);
        end

        // R4: chained sections, echo beyond one section's span
        do_reset();
        for (int n = 0; n < 50; n++) begin
            pa[n] = rnd(8000);
            send(1, pa[n], (n >= N + 3 ? pa[n-N-3] / 2 : 0),
                 rnd(8000), rnd(5000), 1'b1, 1, "R4", 1'b0);
        end

        // R5: direction split, channel B inputs ignored
        do_reset();
        for (int n = 0; n < 40; n++) begin
            pa[n] = rnd(6000);
            pb[n] = rnd(6000);
            send(2, pa[n] + (n >= 2 ? pb[n-2] / 4 : 0), pb[n] + (n >= 1 ? pa[n-1] / 2 : 0),
                 rnd(30000), rnd(30000), 1'b1, 1, "R5", 1'b0);
        end

        // R7: adapt for a while, then freeze and keep filtering
        do_reset();
        for (int n = 0; n < 30; n++) begin
            pa[n] = rnd(8000);
            pb[n] = rnd(8000);
            send(0, pa[n], (n >= 2 ? pa[n-2] / 2 : 0), pb[n], (n >= 1 ? pb[n-1] / 2 : 0),
                 (n < 15), 1, "R7", 1'b0);
        end

        // R8: slow then full step size
        do_reset();
        for (int n = 0; n < 30; n++) begin
            pa[n] = rnd(8000);
            pb[n] = rnd(8000);
            send(0, pa[n], (n >= 1 ? pa[n-1] : 0), pb[n], (n >= 4 ? -pb[n-4] / 2 : 0),
                 1'b1, (n < 20) ? 4 : 0, "R8", 1'b0);
        end

        // R10: drive estimates and differences past full scale
        do_reset();
        for (int n = 0; n < 20; n++)
            send(0, 30000, 30000, -30000, 32767, 1'b1, 0, "R10", 1'b0);
        for (int n = 0; n < 6; n++)
            send(0, 32767, -32768, -32768, 32767, 1'b1, 0, "R10", 1'b0);

        // R9: strobes during a busy pass are ignored; mode 3 acts as mode 0 (R3)
        do_reset();
        sent = 0;
        seen = 0;
        for (int n = 0; n < 10; n++) begin
            pa[n] = rnd(8000);
            send(3, pa[n], (n >= 1 ? pa[n-1] / 2 : 0), rnd(8000), rnd(8000),
                 1'b1, 1, "R9", 1'b1);
        end
        repeat (300) @(negedge clk);
        chk("R9", "done count", seen, sent);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule